// File: doc/BRIEF.md
# PHY Start-up Sync Sequencer

This block runs the start-up handshake that a memory-card interface PHY needs before it can be used. Software programs four 4-bit phase lengths into a 32-bit control register and sets its top bit. The block then drives a sync-enable pulse, waits through a gap, drives a sync-reset pulse, waits a settle period and finishes with a fixed eight-cycle tail. When the run ends, the hardware clears the top bit. Software polls that bit, or watches the ready output, to learn that the PHY may be used.

The same run must be repeated whenever the card clock changes frequency, is stopped and restarted, or the PHY's timing or function settings change. A dedicated retrigger input lets the clock-control logic request a run directly. That request also restarts a run that is already in progress. The phase lengths are captured when a run starts, so software may rewrite the register during a run without disturbing it.

Top module: `phy_init_seq`

## Requirements
- R1: After reset the register reads 0x00000000, `phy_ready` is 1, and `sync_en` and `sync_rst` are 0.
- R2: A write with bit 31 set while no run is active starts a run. `phy_ready` is then 0 for exactly en+gap+rst+settle+8 cycles, counted from the cycle after the write edge. Bit 31 reads 1 during the run and 0 once it has ended. A write with bit 31 clear does not start a run.
- R3: `sync_en` is 1 during the first en cycles of a run, where en is bits [11:8].
- R4: `sync_rst` goes high en+gap cycles into the run and stays high for rst cycles, where gap is bits [7:4] and rst is bits [3:0]. It is never high in the same cycle as `sync_en`.
- R5: After the sync-reset phase, the run holds `phy_ready` low for settle cycles (bits [15:12]) and then for 8 more cycles.
- R6: A phase whose length field is 0 is skipped. When every field is 0, a run lasts 8 cycles and neither pulse appears.
- R7: Bits [15:0], bit 29 (slow flag) and bit 28 (SDIO flag) are read/write. Bit 30 and bits [27:16] always read 0.
- R8: A write during a run, with or without bit 31 set, leaves the run's timing unchanged. Its field and flag values still appear on readback immediately.
- R9: A `clk_retrig` pulse starts a run when the block is idle. During a run it restarts the sequence from its first cycle, using the register's current field values.
- R10: When a register write and `clk_retrig` occur in the same cycle, exactly one run starts from its first cycle, using the field values just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (start bit reflects run state) |
| clk_retrig | input | 1 | Request a run after a clock change or restart |
| sync_en | output | 1 | Sync-enable pulse to the PHY |
| sync_rst | output | 1 | Sync-reset pulse to the PHY |
| phy_ready | output | 1 | High when no run is in progress |

## Verification
A software register write and a retrigger request can arrive in the same cycle. A retrigger can also land in the middle of a run that a write started. The bench covers three cases:
- While idle, it asserts `clk_retrig` together with a write whose start bit is clear.
- During a run, it asserts `clk_retrig` together with a write that carries new field values.
- During a run, it asserts `clk_retrig` alone.

In each case it checks, cycle by cycle, that a single run restarts with the lengths just written, or with the register's current lengths when there is no write. A separate test writes the start bit and new fields during a run. The bench judges that the pulses keep the lengths captured at the start of the run, while the readback already shows the new fields.

// File: rtl/phy_init_seq.sv
module phy_init_seq #(
  parameter int FLD_W    = 4,
  parameter int TAIL_CYC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        clk_retrig,
  output logic        sync_en,
  output logic        sync_rst,
  output logic        phy_ready
);
  localparam int FLDS_W = 4 * FLD_W;
  localparam int MAXLEN = 4 * ((1 << FLD_W) - 1) + TAIL_CYC;
  localparam int CNT_W  = $clog2(MAXLEN + 1);
  localparam int START_B = 31;
  localparam int SLOW_B  = 29;
  localparam int SDIO_B  = 28;

  logic [FLDS_W-1:0] fld_q, snap_q, fld_nxt;
  logic              slow_q, sdio_q, busy_q, go;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  len_rst, len_gap, len_en, len_set;
  logic [CNT_W-1:0]  en_end, rst_beg, rst_end, last;

  assign fld_nxt = reg_wr ? reg_wdata[FLDS_W-1:0] : fld_q;
  assign go      = clk_retrig | (reg_wr & reg_wdata[START_B] & ~busy_q);

  assign len_rst = CNT_W'(snap_q[FLD_W-1:0]);
  assign len_gap = CNT_W'(snap_q[2*FLD_W-1:FLD_W]);
  assign len_en  = CNT_W'(snap_q[3*FLD_W-1:2*FLD_W]);
  assign len_set = CNT_W'(snap_q[4*FLD_W-1:3*FLD_W]);

  assign en_end  = len_en;
  assign rst_beg = len_en + len_gap;
  assign rst_end = rst_beg + len_rst;
  assign last    = rst_end + len_set + CNT_W'(TAIL_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q  <= '0;
      slow_q <= 1'b0;
      sdio_q <= 1'b0;
    end else if (reg_wr) begin
      fld_q  <= reg_wdata[FLDS_W-1:0];
      slow_q <= reg_wdata[SLOW_B];
      sdio_q <= reg_wdata[SDIO_B];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      snap_q <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      snap_q <= fld_nxt;
    end else if (busy_q) begin
      if (cnt_q == last) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign sync_en   = busy_q && (cnt_q < en_end);
  assign sync_rst  = busy_q && (cnt_q >= rst_beg) && (cnt_q < rst_end);
  assign phy_ready = ~busy_q;

  always_comb begin
    reg_rdata = '0;
    reg_rdata[FLDS_W-1:0] = fld_q;
    reg_rdata[SDIO_B]     = sdio_q;
    reg_rdata[SLOW_B]     = slow_q;
    reg_rdata[START_B]    = busy_q;
  end

  assert_pulses_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_en && sync_rst));

  assert_rst_after_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_rst) |-> !sync_en);

  assert_run_undisturbed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$past(clk_retrig)) |->
      (cnt_q == CNT_W'($past(cnt_q) + 1'b1)) && $stable(snap_q));

  assert_retrig_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_retrig |=> busy_q && (cnt_q == '0) && !phy_ready);

  assert_ends_after_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_ready) |-> !$past(sync_en) && !$past(sync_rst));
endmodule

// File: tb/sim_phy_init_seq.sv
`timescale 1ns/1ps
module sim_phy_init_seq;
  localparam real CLK_NS = 5.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        clk_retrig = 1'b0;
  logic [31:0] reg_rdata;
  logic        sync_en, sync_rst, phy_ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [15:0] VEC [6] = '{16'h0000, 16'h0321, 16'h2103,
                                      16'hF0F0, 16'h0F00, 16'hFFFF};

  phy_init_seq u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
                   .reg_rdata(reg_rdata), .clk_retrig(clk_retrig), .sync_en(sync_en),
                   .sync_rst(sync_rst), .phy_ready(phy_ready));

  always #(CLK_NS/2) clk = ~clk;

  task automatic kick(input logic wr, input logic [31:0] wd, input logic rt);
    reg_wr = wr; reg_wdata = wd; clk_retrig = rt;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; clk_retrig = 1'b0;
  endtask

  task automatic chk32(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_seq(input logic [15:0] f, input int k0, input string tag);
    int a, b, c, d, total, bad;
    logic ee, er, ey;
    a = f[11:8]; b = f[7:4]; c = f[3:0]; d = f[15:12];
    total = a + b + c + d + 8;
    bad = 0;
    for (int k = k0; k <= total + 1; k++) begin
      ee = (k < a);
      er = (k >= a + b) && (k < a + b + c);
      ey = (k >= total);
      if (sync_en !== ee || sync_rst !== er || phy_ready !== ey || reg_rdata[31] !== !ey) begin
        if (bad == 0)
          $display("FAIL %s fields=%h k=%0d: actual en=%b rst=%b rdy=%b start=%b expected en=%b rst=%b rdy=%b start=%b",
                   tag, f, k, sync_en, sync_rst, phy_ready, reg_rdata[31], ee, er, ey, !ey);
        bad++;
      end
      @(negedge clk);
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk32(reg_rdata, 32'h0, "R1 rdata");
    chk32({29'b0, phy_ready, sync_en, sync_rst}, 32'h4, "R1 outputs");
    rst_n = 1'b1;
    @(negedge clk);

    // Table of phase lengths: R2 R3 R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      kick(1'b1, {1'b1, 15'b0, VEC[i]}, 1'b0);
      check_seq(VEC[i], 0, "R2 R3 R4 R5 R6 table");
    end

    // R7 read/write bits; R2 no start without bit 31
    kick(1'b1, 32'h7FFF_FFFF, 1'b0);
    chk32(reg_rdata, 32'h3000_FFFF, "R7 readback");
    @(negedge clk);
    chk32({31'b0, phy_ready}, 32'h1, "R2 no start with bit31 clear");
    kick(1'b1, 32'h0000_1234, 1'b0);
    chk32(reg_rdata, 32'h0000_1234, "R7 flags cleared");

    // R8 write during run
    kick(1'b1, {1'b1, 15'b0, 16'h1322}, 1'b0);
    repeat (3) @(negedge clk);
    kick(1'b1, {1'b1, 1'b0, 1'b1, 13'b0, 16'h0101}, 1'b0);
    chk32(reg_rdata, 32'hA000_0101, "R8 readback during run");
    check_seq(16'h1322, 4, "R8 run undisturbed");
    chk32(reg_rdata, 32'h2000_0101, "R8 R2 start bit cleared");

    // R9 retrigger while idle
    kick(1'b0, 32'h0, 1'b1);
    check_seq(16'h0101, 0, "R9 idle retrigger");

    // R9 retrigger mid-run
    kick(1'b1, {1'b1, 15'b0, 16'h1321}, 1'b0);
    repeat (4) @(negedge clk);
    kick(1'b0, 32'h0, 1'b1);
    check_seq(16'h1321, 0, "R9 restart mid-run");

    // R10 write + retrigger mid-run
    kick(1'b1, {1'b1, 15'b0, 16'h0222}, 1'b0);
    repeat (2) @(negedge clk);
    kick(1'b1, {1'b1, 15'b0, 16'h3113}, 1'b1);
    check_seq(16'h3113, 0, "R10 write+retrigger busy");

    // R10 write without start + retrigger while idle
    kick(1'b1, {16'h0, 16'h0140}, 1'b1);
    check_seq(16'h0140, 0, "R10 write+retrigger idle");
    chk32(reg_rdata, 32'h0000_0140, "R10 R2 final readback");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule